// File: doc/BRIEF.md
# Synchronous 8-bit serial shift port

This block is a clocked serial port that moves one byte in and one byte out together. A single shift register is both the transmit and the receive buffer. While a transfer runs, each cycle of an externally supplied shift clock sends one bit on the serial output and takes one bit from the serial input. After eight bits the register holds the received byte, and the port stops by itself.

A processor reaches the port through two word addresses. Address 0 is the data register. Address 1 is the control register, which holds a run bit, a completion flag, an interrupt enable and a bit-order select. The end of every transfer sets the completion flag. A level interrupt output is high whenever the flag and the enable are both 1. Two instances can each drive their own interrupt line. The shift clock is synchronised into the system clock domain and edge-detected, so all register state changes on the system clock.

Top module: `sio_shift_port`

## Requirements
- R1: With control bit 3 = 0, the port sends the data register MSB first. After eight shift-clock cycles, address 0 reads back the eight sampled input bits, first bit in bit 7.
- R2: With control bit 3 = 1, the port sends LSB first. The first received bit ends up in bit 0.
- R3: The completion flag (control bit 1) is set on the eighth rising edge of the shift clock, whatever the interrupt enable is. At the same time the run bit (control bit 0) clears by itself.
- R4: The interrupt output equals flag AND enable (control bit 2). A control write that sets the enable while the flag is 1 raises the interrupt on the very next cycle.
- R5: Writing 0 to control bit 1 clears the flag. Writing 1 to control bit 1 leaves the flag as it was.
- R6: Writing 0 to the run bit during a transfer aborts it: the serial output goes high and the flag is not set. This also holds when the write lands in the same cycle as the eighth rising edge.
- R7: Writes to address 0 while the run bit is 1 are ignored.
- R8: The serial output changes only on a falling shift-clock edge, at the start of a transfer, or when a transfer ends. Input is sampled on the rising edge. Whenever no transfer runs, the serial output is high.
- R9: After reset, the data register reads 0, the control register reads 0, the interrupt output is low and the serial output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_en | input | 1 | Register write strobe |
| cpu_addr | input | 1 | Register select: 0 data, 1 control |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| sck_in | input | 1 | External shift clock, idle high |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| irq | output | 1 | Level interrupt request |

## Verification
A bad bit counter shows up at the ports at the end of the byte. The flag and the interrupt then rise one shift-clock cycle early or late, and the received byte is misaligned, so checks made right after the eighth rising edge catch it. A wrong bit-order or shift-direction state corrupts the output stream from the first falling edge on, which the per-bit output compares reveal. A flag that ignores the stop or clear rules appears on the interrupt pin within one system clock of the write that should have blocked it.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_FLAG = 1;
    localparam int CTRL_IE   = 2;
    localparam int CTRL_LSB  = 3;
endpackage

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/sio_bit_counter.sv
module sio_bit_counter #(
    parameter int WIDTH = 3,
    parameter int LAST  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)     cnt_d = '0;
        else if (step) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == WIDTH'(LAST));
endmodule

// File: rtl/sio_shift_port.sv
module sio_shift_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic              cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              sck_in,
    input  logic              sdi,
    output logic              sdo,
    output logic              irq
);
    import sio_pkg::*;

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic              run;
        logic              flag;
        logic              ie;
        logic              lsb;
        logic              sdo;
    } state_t;

    state_t st_d, st_q;

    logic sck_rise, sck_fall, cnt_last, cnt_clr, cnt_step;
    logic wr_ctrl, wr_data, done_evt, stop_req, set_flag, clr_flag;

    sio_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sck_in),
        .rise     (sck_rise),
        .fall     (sck_fall)
    );

    sio_bit_counter #(.WIDTH(CNT_W), .LAST(DATA_W-1)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clr),
        .step  (cnt_step),
        .last  (cnt_last)
    );

    always_comb begin
        st_d     = st_q;
        wr_ctrl  = cpu_wr_en && (cpu_addr == ADDR_CTRL);
        wr_data  = cpu_wr_en && (cpu_addr == ADDR_DATA);
        cnt_clr  = 1'b0;
        cnt_step = st_q.run && sck_rise;
        done_evt = st_q.run && sck_rise && cnt_last;
        stop_req = wr_ctrl && !cpu_wdata[CTRL_RUN];
        set_flag = done_evt && !stop_req;
        clr_flag = wr_ctrl && !cpu_wdata[CTRL_FLAG];

        if (st_q.run && sck_rise) begin
            if (st_q.lsb) st_d.shreg = {sdi, st_q.shreg[DATA_W-1:1]};
            else          st_d.shreg = {st_q.shreg[DATA_W-2:0], sdi};
        end
        if (st_q.run && sck_fall) begin
            st_d.sdo = st_q.lsb ? st_q.shreg[0] : st_q.shreg[DATA_W-1];
        end
        if (done_evt) begin
            st_d.run = 1'b0;
            st_d.sdo = 1'b1;
        end
        if (wr_data && !st_q.run) begin
            st_d.shreg = cpu_wdata;
        end
        if (wr_ctrl) begin
            st_d.ie = cpu_wdata[CTRL_IE];
            if (!st_q.run) begin
                st_d.lsb = cpu_wdata[CTRL_LSB];
                if (cpu_wdata[CTRL_RUN]) begin
                    st_d.run = 1'b1;
                    cnt_clr  = 1'b1;
                    st_d.sdo = cpu_wdata[CTRL_LSB] ? st_q.shreg[0]
                                                   : st_q.shreg[DATA_W-1];
                end
            end else if (stop_req) begin
                st_d.run = 1'b0;
                st_d.sdo = 1'b1;
            end
        end
        if (set_flag)      st_d.flag = 1'b1;
        else if (clr_flag) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.sdo   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr == ADDR_CTRL) begin
            cpu_rdata[CTRL_RUN]  = st_q.run;
            cpu_rdata[CTRL_FLAG] = st_q.flag;
            cpu_rdata[CTRL_IE]   = st_q.ie;
            cpu_rdata[CTRL_LSB]  = st_q.lsb;
        end else begin
            cpu_rdata = st_q.shreg;
        end
    end

    assign sdo = st_q.sdo;
    assign irq = st_q.flag && st_q.ie;
endmodule

// File: rtl/sio_shift_port_chk.sv
module sio_shift_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ctrl,
    input logic              wr_run,
    input logic              wr_flag,
    input logic              wr_ie,
    input logic              run_q,
    input logic              flag_q,
    input logic              rise,
    input logic              fall,
    input logic [DATA_W-1:0] shreg,
    input logic              sdo,
    input logic              irq
);
    AST_FLAG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(run_q)); // R3
    AST_IRQ_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_ie && wr_flag && flag_q) |=> irq); // R4
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wr_flag && !rise) |=> !flag_q); // R5
    AST_STOP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wr_run && !flag_q) |=> !flag_q); // R6
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !rise) |=> $stable(shreg)); // R7
    AST_IDLE_SDO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> sdo); // R8
    AST_SDO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !fall && !rise && !wr_ctrl) |=> $stable(sdo)); // R8
endmodule

bind sio_shift_port sio_shift_port_chk #(.DATA_W(DATA_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (cpu_wr_en && (cpu_addr == sio_pkg::ADDR_CTRL)),
    .wr_run  (cpu_wdata[sio_pkg::CTRL_RUN]),
    .wr_flag (cpu_wdata[sio_pkg::CTRL_FLAG]),
    .wr_ie   (cpu_wdata[sio_pkg::CTRL_IE]),
    .run_q   (st_q.run),
    .flag_q  (st_q.flag),
    .rise    (sck_rise),
    .fall    (sck_fall),
    .shreg   (st_q.shreg),
    .sdo     (sdo),
    .irq     (irq)
);

// File: tb/test_sio_shift_port.sv
module test_sio_shift_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr_en = 1'b0;
    logic       cpu_addr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       sck_in = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo, irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sio_shift_port i_sio_shift_port (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sck_in(sck_in),
        .sdi(sdi), .sdo(sdo), .irq(irq)
    );

    // {lsb_first, tx byte, rx byte}
    localparam logic [16:0] VEC [4] = '{
        {1'b0, 8'hA5, 8'h3C},
        {1'b0, 8'hFF, 8'h00},
        {1'b1, 8'h81, 8'h96},
        {1'b1, 8'h0F, 8'hE1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic shift_bit(input logic din, output logic dout, output logic dhold);
        @(negedge clk);
        sck_in = 1'b0;
        repeat (4) @(negedge clk);
        dout = sdo;
        sdi = din;
        sck_in = 1'b1;
        @(negedge clk);
        dhold = sdo;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [7:0] r;
        logic b, h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        rd(1'b0, r); chk("R9 data", r, 8'h00);
        rd(1'b1, r); chk("R9 ctrl", r, 8'h00);
        chk("R9 sdo", sdo, 1'b1);
        chk("R9 irq", irq, 1'b0);

        // R5 writing 1 to the flag bit does not set it
        wr(1'b1, 8'h02);
        rd(1'b1, r); chk("R5 write one", r[1], 1'b0);

        // vector table walk
        foreach (VEC[i]) begin
            logic lsb;
            logic [7:0] tx, rx, got_out;
            lsb = VEC[i][16]; tx = VEC[i][15:8]; rx = VEC[i][7:0];
            got_out = '0;
            wr(1'b0, tx);
            wr(1'b1, {4'b0, lsb, 1'b1, 1'b1, 1'b1});
            for (int k = 0; k < 8; k++) begin
                shift_bit(lsb ? rx[k] : rx[7-k], b, h);
                if (lsb) got_out[k] = b; else got_out[7-k] = b;
                if (k < 7) chk("R8 sdo held after rise", h, b);
            end
            chk(lsb ? "R2 sent stream" : "R1 sent stream", got_out, tx);
            rd(1'b0, r); chk(lsb ? "R2 received" : "R1 received", r, rx);
            rd(1'b1, r); chk("R3 run cleared, flag set", r[1:0], 2'b10);
            chk("R4 irq high", irq, 1'b1);
            chk("R8 sdo idle high", sdo, 1'b1);
            wr(1'b1, {4'b0, lsb, 1'b1, 1'b0, 1'b0});
            rd(1'b1, r); chk("R5 flag cleared", r[1], 1'b0);
            chk("R5 irq low", irq, 1'b0);
        end

        // R3 flag set with interrupts disabled; R4 immediate on enable
        wr(1'b0, 8'h55);
        wr(1'b1, 8'h01);
        for (int k = 0; k < 8; k++) shift_bit(1'b1, b, h);
        rd(1'b1, r); chk("R3 flag with ie off", r[1:0], 2'b10);
        chk("R4 irq off", irq, 1'b0);
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_addr = 1'b1; cpu_wdata = 8'h06;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        chk("R4 immediate irq", irq, 1'b1);
        wr(1'b1, 8'h00);

        // R7 data writes ignored during a transfer
        wr(1'b0, 8'hC3);
        wr(1'b1, 8'h01);
        for (int k = 0; k < 3; k++) shift_bit(1'b0, b, h);
        wr(1'b0, 8'h00);
        for (int k = 3; k < 8; k++) shift_bit(1'b0, b, h);
        chk("R7 tail bit from original byte", b, 1'b1);
        rd(1'b0, r); chk("R7 received", r, 8'h00);
        wr(1'b1, 8'h00);

        // R6 abort mid transfer
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h01);
        for (int k = 0; k < 3; k++) shift_bit(1'b1, b, h);
        chk("R6 sdo low before abort", sdo, 1'b0);
        wr(1'b1, 8'h02);
        chk("R6 sdo high after abort", sdo, 1'b1);
        for (int k = 0; k < 6; k++) shift_bit(1'b1, b, h);
        rd(1'b1, r); chk("R6 no flag after abort", r[1:0], 2'b00);

        // R6 stop in the same cycle as the eighth rising edge
        wr(1'b1, 8'h05);
        for (int k = 0; k < 7; k++) shift_bit(1'b0, b, h);
        @(negedge clk);
        sck_in = 1'b0;
        repeat (4) @(negedge clk);
        sck_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_addr = 1'b1; cpu_wdata = 8'h06;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        repeat (4) @(negedge clk);
        rd(1'b1, r); chk("R6 coincident stop flag", r[1:0], 2'b00);
        chk("R6 coincident stop irq", irq, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule